// File: doc/BRIEF.md
# Slow-Region Read Stretcher

This block produces the ready line for a two-phase processor bus. A single phase input is low during Phase 1 and high during Phase 2. The processor samples ready when Phase 2 begins. A low ready on a read makes it repeat the cycle and read the data bus one cycle later. The block decodes the bus address against a slow memory window. For every read that lands in that window, it holds ready low for a fixed number of Phase 2 starts (0 to 7) so that a slow device gets time to answer.

The bus cannot lengthen a write, so the block never pulls ready low on a write. When a write targets the slow window, the block raises a one-clock flag so that the surrounding system or a bench can spot the access it was unable to stretch. Everything runs on one fast system clock. The block finds the start of Phase 2 as the rising edge of the phase input.

Top module: `rws_ready_gen`

## Requirements
- R1: A read (bus_rw = 1) whose address lies in the slow window holds bus_ready low at exactly WAIT_CYC consecutive Phase 2 starts of that repeated read. bus_ready is high at the next Phase 2 start.
- R2: A write (bus_rw = 0) never drives bus_ready low, whatever the address.
- R3: An access outside the slow window leaves bus_ready high.
- R4: A write to the slow window sets slow_wr_hit high for exactly one clock: the clock after the Phase 2 start of that write. Reads and writes outside the window never set it.
- R5: bus_ready is high after reset and stays high whenever no slow-window read is presented.
- R6: Each new slow-window read that follows a completed one reloads the full count of WAIT_CYC waits.
- R7: If a Phase 2 start during a wait carries a write or an address outside the window, the wait is dropped and bus_ready is high. The next slow read starts a full new count.
- R8: A Phase 2 start is a low-to-high transition of bus_ph2 only. A phase input held high counts once. A phase input already high when reset is released does not count.
- R9: With the default range decode, the window is inclusive: SLOW_BASE and SLOW_LAST are slow, while SLOW_BASE-1 and SLOW_LAST+1 are not.
- R10: With WAIT_CYC = 0, no read is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ph2 | input | 1 | Bus phase: 0 in Phase 1, 1 in Phase 2 |
| bus_addr | input | ADDR_W | Bus address |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_ready | output | 1 | Ready to the processor; low requests another cycle |
| slow_wr_hit | output | 1 | One-clock pulse for a write to the slow window |

## Verification
The embedded assertions watch several properties on every clock:
- writes and out-of-window accesses never see ready low;
- the write flag is a single-clock pulse caused by a slow write;
- Phase 2 starts never come back to back;
- the counter reloads, counts down by one per start, and is cleared by an abort.

Only the bench's scenarios can show the exact number of stalled Phase 2 starts per read and the reload between consecutive slow reads. The same holds for the inclusive window edges, the handling of a phase input held high across reset, and the behaviour of a zero-wait build. The bench compares both builds against a behavioural model on every clock.

// File: rtl/rws_pkg.sv
package rws_pkg;
   // widest wait count the block supports
   localparam int MAX_WAIT = 7;
   localparam int CNT_W    = 3;

   typedef enum logic [0:0] {
      DEC_RANGE = 1'b0,   // inclusive base..last compare
      DEC_MASK  = 1'b1    // masked address match
   } dec_kind_e;
endpackage

// File: rtl/rws_phase_edge.sv
module rws_phase_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ph2,
   output logic ph2_start
);
   logic ph2_q;

   // reset to 1 so a phase already high at release is not a start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph2_q <= 1'b1;
      else        ph2_q <= ph2;
   end

   assign ph2_start = ph2 & ~ph2_q;

   assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ph2_start |=> !ph2_start);
endmodule

// File: rtl/rws_range_decode.sv
module rws_range_decode #(
   parameter int                  ADDR_W     = 16,
   parameter rws_pkg::dec_kind_e  DEC_KIND   = rws_pkg::DEC_RANGE,
   parameter logic [ADDR_W-1:0]   SLOW_BASE  = '0,
   parameter logic [ADDR_W-1:0]   SLOW_LAST  = '1,
   parameter logic [ADDR_W-1:0]   SLOW_MASK  = '0,
   parameter logic [ADDR_W-1:0]   SLOW_MATCH = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   generate
      if (DEC_KIND == rws_pkg::DEC_RANGE) begin : g_range
         if (SLOW_BASE > SLOW_LAST) begin : g_bad_range
            $error("rws_range_decode: SLOW_BASE above SLOW_LAST");
         end
         assign hit = (addr >= SLOW_BASE) && (addr <= SLOW_LAST);
      end else begin : g_mask
         if ((SLOW_MATCH & ~SLOW_MASK) != '0) begin : g_bad_mask
            $error("rws_range_decode: match bits outside mask");
         end
         assign hit = ((addr & SLOW_MASK) == SLOW_MATCH);
      end
   endgenerate
endmodule

// File: rtl/rws_wait_ctr.sv
module rws_wait_ctr #(
   parameter int WAIT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ph2_start,
   input  logic slow_rd,
   output logic hold
);
   import rws_pkg::*;

   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYC - 1);

   logic             busy;
   logic [CNT_W-1:0] rem;

   // stall while a slow read is presented and waits remain
   assign hold = slow_rd & (~busy | (rem != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rem  <= '0;
      end else if (ph2_start) begin
         if (slow_rd) begin
            if (!busy) begin
               busy <= 1'b1;
               rem  <= RELOAD;
            end else if (rem == '0) begin
               busy <= 1'b0;
            end else begin
               rem <= rem - 1'b1;
            end
         end else begin
            busy <= 1'b0;
         end
      end
   end

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2_start && slow_rd && !busy) |=> (busy && rem == RELOAD));
   assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem <= RELOAD));
   assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2_start && slow_rd && busy && rem != '0) |=> (rem == $past(rem) - 1'b1));
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2_start && !slow_rd) |=> !busy);
   assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ph2_start |=> ($stable(rem) && $stable(busy)));
endmodule

// File: rtl/rws_ready_gen.sv
module rws_ready_gen #(
   parameter int                  ADDR_W     = 16,
   parameter int                  WAIT_CYC   = 3,
   parameter rws_pkg::dec_kind_e  DEC_KIND   = rws_pkg::DEC_RANGE,
   parameter logic [ADDR_W-1:0]   SLOW_BASE  = 16'hC000,
   parameter logic [ADDR_W-1:0]   SLOW_LAST  = 16'hCFFF,
   parameter logic [ADDR_W-1:0]   SLOW_MASK  = 16'hF000,
   parameter logic [ADDR_W-1:0]   SLOW_MATCH = 16'hC000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ph2,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rw,
   output logic              bus_ready,
   output logic              slow_wr_hit
);
   import rws_pkg::*;

   if (WAIT_CYC < 0 || WAIT_CYC > MAX_WAIT) begin : g_bad_wait
      $error("rws_ready_gen: WAIT_CYC out of range");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("rws_ready_gen: ADDR_W must be positive");
   end

   logic ph2_start;
   logic slow_hit;
   logic slow_rd;
   logic hold;

   rws_phase_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph2       (bus_ph2),
      .ph2_start (ph2_start)
   );

   rws_range_decode #(
      .ADDR_W     (ADDR_W),
      .DEC_KIND   (DEC_KIND),
      .SLOW_BASE  (SLOW_BASE),
      .SLOW_LAST  (SLOW_LAST),
      .SLOW_MASK  (SLOW_MASK),
      .SLOW_MATCH (SLOW_MATCH)
   ) u_dec (
      .addr (bus_addr),
      .hit  (slow_hit)
   );

   assign slow_rd = slow_hit & bus_rw;

   generate
      if (WAIT_CYC == 0) begin : g_no_wait
         assign hold = 1'b0;
      end else begin : g_wait
         rws_wait_ctr #(.WAIT_CYC(WAIT_CYC)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ph2_start (ph2_start),
            .slow_rd   (slow_rd),
            .hold      (hold)
         );
      end
   endgenerate

   assign bus_ready = ~hold;

   // report a write the bus cannot stretch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slow_wr_hit <= 1'b0;
      else        slow_wr_hit <= ph2_start & slow_hit & ~bus_rw;
   end

   assert_write_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rw |-> bus_ready);
   assert_fast_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_hit |-> bus_ready);
   assert_flag_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slow_wr_hit |=> !slow_wr_hit);
   assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slow_wr_hit |-> $past(ph2_start && slow_hit && !bus_rw));
   assert_zero_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (WAIT_CYC == 0) |-> bus_ready);
endmodule

// File: tb/rws_ready_gen_tb.sv
module rws_ready_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W_MAIN     = 3;
   localparam logic [15:0] BASE = 16'hC000;
   localparam logic [15:0] LAST = 16'hCFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ph2 = 1'b1;
   logic [15:0] addr = 16'h0000;
   logic        rw = 1'b1;
   logic        rdy3, flag3, rdy0, flag0;

   int    n_total = 0;
   int    n_fail  = 0;
   bit    running = 1'b0;
   bit    done    = 1'b0;
   string cur_req = "R5";

   // model state
   int prev_ph2 = 1;
   int stalls3  = 0;
   int stalls0  = 0;
   bit exp_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rws_ready_gen #(.WAIT_CYC(W_MAIN), .SLOW_BASE(BASE), .SLOW_LAST(LAST)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_ph2(ph2), .bus_addr(addr), .bus_rw(rw),
      .bus_ready(rdy3), .slow_wr_hit(flag3));

   rws_ready_gen #(.WAIT_CYC(0), .SLOW_BASE(BASE), .SLOW_LAST(LAST)) u_dut0 (
      .clk(clk), .rst_n(rst_n), .bus_ph2(ph2), .bus_addr(addr), .bus_rw(rw),
      .bus_ready(rdy0), .slow_wr_hit(flag0));

   function automatic bit in_window(logic [15:0] a);
      return (a >= BASE) && (a <= LAST);
   endfunction

   // behavioural reference: count stalls served for the current slow read
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ph2 = 1; stalls3 = 0; stalls0 = 0; exp_flag = 1'b0;
      end else begin
         bit start;
         start    = (ph2 == 1'b1) && (prev_ph2 == 0);
         prev_ph2 = ph2;
         exp_flag = start && in_window(addr) && !rw;
         if (start) begin
            if (in_window(addr) && rw) begin
               if (stalls3 < W_MAIN) stalls3++; else stalls3 = 0;
               stalls0 = 0;
            end else begin
               stalls3 = 0; stalls0 = 0;
            end
         end
      end
   end

   task automatic check(string req, string what, logic got, logic exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0b expected %0b (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         bit slow_rd;
         slow_rd = in_window(addr) && rw;
         check(cur_req, "ready", rdy3, !(slow_rd && stalls3 < W_MAIN));
         check(cur_req, "write flag", flag3, exp_flag);
         check("R10", "ready zero-wait", rdy0, 1'b1);
         check("R10", "write flag zero-wait", flag0, exp_flag);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   // one bus cycle: Phase 1 for p1 clocks then Phase 2 for p2 clocks
   task automatic bus_cycle(logic [15:0] a, logic r, int p1, int p2);
      ph2 = 1'b0; addr = a; rw = r;
      step(p1);
      ph2 = 1'b1;
      step(p2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_total++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R8/R5: phase high across reset release must not count as a start
      rst_n = 1'b0; ph2 = 1'b1; addr = 16'hC004; rw = 1'b1;
      step(3);
      running = 1'b1;
      cur_req = "R8";
      rst_n = 1'b1;
      step(3);
      cur_req = "R5";
      addr = 16'h0040;
      step(2);

      cur_req = "R3";
      repeat (2) bus_cycle(16'h1234, 1'b1, 2, 2);
      bus_cycle(16'hFFFF, 1'b1, 2, 2);

      cur_req = "R1";
      repeat (W_MAIN + 1) bus_cycle(16'hC010, 1'b1, 2, 2);

      cur_req = "R6";
      repeat (W_MAIN + 1) bus_cycle(16'hC010, 1'b1, 2, 2);
      repeat (W_MAIN + 1) bus_cycle(16'hC200, 1'b1, 2, 2);

      cur_req = "R9";
      repeat (W_MAIN + 1) bus_cycle(BASE, 1'b1, 2, 2);
      repeat (W_MAIN + 1) bus_cycle(LAST, 1'b1, 2, 2);
      bus_cycle(BASE - 16'd1, 1'b1, 2, 2);
      bus_cycle(LAST + 16'd1, 1'b1, 2, 2);

      cur_req = "R4";
      repeat (2) bus_cycle(16'hC100, 1'b0, 2, 3);
      cur_req = "R2";
      bus_cycle(16'h0200, 1'b0, 2, 3);
      bus_cycle(LAST, 1'b0, 3, 2);

      cur_req = "R7";
      bus_cycle(16'hC020, 1'b1, 2, 2);
      bus_cycle(16'hC020, 1'b0, 2, 2);
      repeat (W_MAIN + 1) bus_cycle(16'hC020, 1'b1, 2, 2);
      bus_cycle(16'hC020, 1'b1, 2, 2);
      bus_cycle(16'h3000, 1'b1, 2, 2);
      repeat (W_MAIN + 1) bus_cycle(16'hC020, 1'b1, 2, 2);

      cur_req = "R8";
      repeat (W_MAIN + 1) bus_cycle(16'hC030, 1'b1, 1, 6);

      cur_req = "R5";
      bus_cycle(16'h0000, 1'b1, 2, 2);
      step(2);
      finish_run();
   end
endmodule